// File: doc/BRIEF.md
# Relaxed-Format Floating-Point Adder

This block adds two 32-bit floating-point words in a relaxed format. The word keeps the familiar single-precision layout: a sign bit, an 8-bit exponent and a 23-bit significand. Unlike the standard format, the significand has no hidden leading one. A word stands for (-1)^sign × 0.significand × 2^exponent, where the exponent bias is left to the user. Operands need not be normalized. Zero and very small values are ordinary encodings, and the format has no NaN, infinity or exception flags.

The datapath is combinational and has three steps. It first aligns the exponents. It then adds or subtracts the significands, with a correction when the significand overflows. Finally it optionally shifts the result left by one or two places. A single output register captures the result. Two parameters set the cost and accuracy of the adder. `NORM_MODE` picks no left normalization (0) or limited normalization of up to two places (1). `ROUND_MODE` picks plain truncation (0) or half-unit-biased round-to-nearest (1). Half-unit-biased rounding appends an implicit trailing one to each significand and then simply truncates.

Top module: `nnfp_adder`

## Requirements
- R1: Word layout is sign in bit 31, exponent in bits 30:23 and significand in bits 22:0, with no hidden bit; a value of 0.significand × 2^exponent is assumed throughout.
- R2: The result appears on `sum_q` one clock after the operands are applied. A synchronous active-high reset clears `sum_q` to all zeros.
- R3: When the signs agree, the aligned significands are added and the result takes the common sign.
- R4: When the signs differ, the smaller aligned significand is subtracted from the larger one, and the result takes the sign of the larger. This holds even when the operand with the larger exponent has the smaller aligned significand.
- R5: The significand of the operand with the smaller exponent is shifted right by the exponent difference. Bits shifted out are discarded, and the result exponent is the larger exponent.
- R6: A carry out of the significand sum shifts the significand right one place and adds one to the exponent.
- R7: If a carry occurs while the exponent is already 255, the result is exponent 255, significand all ones, and the sign unchanged.
- R8: An exactly zero working result gives the all-zero word, with sign 0 and exponent 0.
- R9: If the exponent difference exceeds 23, the word with the larger exponent is output bit for bit. A difference of exactly 23 still goes through the arithmetic path.
- R10: With `NORM_MODE`=1, a result without a carry has up to two leading zeros removed by a left shift, and the exponent is reduced by the shift. With `NORM_MODE`=0, no left shift is done.
- R11: The left shift is limited so that the exponent never goes below 0.
- R12: With `ROUND_MODE`=1, each significand is extended with a trailing one below its LSB before alignment, and the final significand is the top 23 bits of the working result. With `ROUND_MODE`=0, the working width is 23 bits and all dropped bits are truncated.
- R13: Swapping `op_a` and `op_b` does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| sum_q | output | 32 | Registered sum word |

## Verification
The bench targets unnormalized subtraction in which the larger-exponent operand has the smaller aligned significand. A design that picks the minuend by exponent alone wraps the significand and gets the wrong sign there. It probes exponent differences of exactly 23 and 24 to separate the bypass path from a shift that flushes the smaller significand to zero. An off-by-one threshold shows up there as a spurious zero word or a different exponent. It also checks carry at exponent 255, which a design without saturation wraps to a tiny exponent. It checks left shifts near exponent 0, where an unclamped shift wraps the exponent to 255. Finally it checks exact cancellation and operand swaps, where a mishandled zero leaves a stray sign or exponent.

// File: rtl/nnfp_pkg.sv
package nnfp_pkg;
  localparam int NORM_NONE    = 0;
  localparam int NORM_LIMITED = 1;
  localparam int RND_TRUNC    = 0;
  localparam int RND_HUB      = 1;
  localparam int MAX_LSHIFT   = 2;
endpackage

// File: rtl/nnfp_align.sv
module nnfp_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int HB    = 1
) (
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  output logic [EXP_W-1:0]       exp_big,
  output logic [MAN_W+HB-1:0]    sig_big,
  output logic [MAN_W+HB-1:0]    sig_small,
  output logic                   sign_big,
  output logic                   sign_small,
  output logic                   bypass,
  output logic [EXP_W+MAN_W:0]   pass_word
);
  localparam int EW = MAN_W + HB;

  logic [EXP_W-1:0] ea, eb, exp_small, diff;
  logic [MAN_W-1:0] ma, mb;
  logic [EW-1:0]    xa, xb, x_small;
  logic             a_big;
  logic [31:0]      diff32;

  assign ea = op_a[EXP_W+MAN_W-1:MAN_W];
  assign eb = op_b[EXP_W+MAN_W-1:MAN_W];
  assign ma = op_a[MAN_W-1:0];
  assign mb = op_b[MAN_W-1:0];

  generate
    if (HB != 0) begin : g_hub_ext
      assign xa = {ma, 1'b1};
      assign xb = {mb, 1'b1};
    end else begin : g_plain_ext
      assign xa = ma;
      assign xb = mb;
    end
  endgenerate

  assign a_big      = (ea >= eb);
  assign exp_big    = a_big ? ea : eb;
  assign exp_small  = a_big ? eb : ea;
  assign sign_big   = a_big ? op_a[EXP_W+MAN_W] : op_b[EXP_W+MAN_W];
  assign sign_small = a_big ? op_b[EXP_W+MAN_W] : op_a[EXP_W+MAN_W];
  assign sig_big    = a_big ? xa : xb;
  assign x_small    = a_big ? xb : xa;
  assign diff       = exp_big - exp_small;
  assign diff32     = 32'(diff);
  assign sig_small  = x_small >> diff;
  assign bypass     = diff32 > 32'(MAN_W);
  assign pass_word  = a_big ? op_a : op_b;

  // R5: the aligned exponent is never below the other operand's exponent
  always_comb begin
    p_align_order_r5: assert (exp_big >= exp_small);
  end
endmodule

// File: rtl/nnfp_addsub.sv
module nnfp_addsub #(
  parameter int EW = 24
) (
  input  logic [EW-1:0] sig_big,
  input  logic [EW-1:0] sig_small,
  input  logic          sign_big,
  input  logic          sign_small,
  output logic [EW:0]   mag,
  output logic          sign_out,
  output logic          is_zero
);
  logic eff_sub, small_wins;

  assign eff_sub    = sign_big ^ sign_small;
  assign small_wins = sig_small > sig_big;

  always_comb begin
    if (!eff_sub) begin
      mag      = {1'b0, sig_big} + {1'b0, sig_small};
      sign_out = sign_big;
    end else if (small_wins) begin
      mag      = {1'b0, sig_small} - {1'b0, sig_big};
      sign_out = sign_small;
    end else begin
      mag      = {1'b0, sig_big} - {1'b0, sig_small};
      sign_out = sign_big;
    end
  end

  assign is_zero = (mag == '0);

  // R4: a magnitude subtraction never produces a carry out
  always_comb begin
    p_sub_no_carry_r4: assert (!(eff_sub && mag[EW]));
  end
endmodule

// File: rtl/nnfp_norm.sv
module nnfp_norm #(
  parameter int EXP_W     = 8,
  parameter int MAN_W     = 23,
  parameter int HB        = 1,
  parameter int NORM_MODE = 1
) (
  input  logic [MAN_W+HB:0]    mag,
  input  logic [EXP_W-1:0]     exp_in,
  input  logic                 sign_in,
  input  logic                 is_zero,
  input  logic                 bypass,
  input  logic [EXP_W+MAN_W:0] pass_word,
  output logic [EXP_W+MAN_W:0] result
);
  import nnfp_pkg::*;
  localparam int EW = MAN_W + HB;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic             carry, sat;
  logic [EW-1:0]    m_pre, m_fin;
  logic [EXP_W-1:0] e_pre, e_fin;

  assign carry = mag[EW];
  assign sat   = carry && (exp_in == EXP_MAX);

  always_comb begin
    if (carry) begin
      m_pre = mag[EW:1];
      e_pre = exp_in + 1'b1;
    end else begin
      m_pre = mag[EW-1:0];
      e_pre = exp_in;
    end
  end

  generate
    if (NORM_MODE == NORM_LIMITED) begin : g_limited
      logic [1:0] lz, sh;
      always_comb begin
        if (m_pre[EW-1])      lz = 2'd0;
        else if (m_pre[EW-2]) lz = 2'd1;
        else                  lz = 2'(MAX_LSHIFT);
        if (e_pre < EXP_W'(lz)) sh = e_pre[1:0];
        else                    sh = lz;
      end
      assign m_fin = m_pre << sh;
      assign e_fin = e_pre - EXP_W'(sh);

      // R11: the left shift never wraps the exponent past zero
      always_comb begin
        p_no_wrap_r11: assert (e_fin <= e_pre);
      end
    end else begin : g_none
      assign m_fin = m_pre;
      assign e_fin = e_pre;
    end
  endgenerate

  always_comb begin
    if (bypass)       result = pass_word;
    else if (is_zero) result = '0;
    else if (sat)     result = {sign_in, EXP_MAX, {MAN_W{1'b1}}};
    else              result = {sign_in, e_fin, m_fin[EW-1:HB]};
  end
endmodule

// File: rtl/nnfp_adder.sv
module nnfp_adder #(
  parameter int EXP_W      = 8,
  parameter int MAN_W      = 23,
  parameter int NORM_MODE  = 1,
  parameter int ROUND_MODE = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output logic [EXP_W+MAN_W:0] sum_q
);
  import nnfp_pkg::*;
  localparam int HB = (ROUND_MODE == RND_HUB) ? 1 : 0;
  localparam int EW = MAN_W + HB;

  logic [EXP_W-1:0]     exp_big;
  logic [EW-1:0]        sig_big, sig_small;
  logic                 sign_big, sign_small, bypass_c;
  logic [EXP_W+MAN_W:0] pass_c, result_c;
  logic [EW:0]          mag;
  logic                 sign_r, zero_c;

  nnfp_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .HB(HB)) u_align (
    .op_a(op_a), .op_b(op_b), .exp_big(exp_big), .sig_big(sig_big),
    .sig_small(sig_small), .sign_big(sign_big), .sign_small(sign_small),
    .bypass(bypass_c), .pass_word(pass_c)
  );

  nnfp_addsub #(.EW(EW)) u_addsub (
    .sig_big(sig_big), .sig_small(sig_small), .sign_big(sign_big),
    .sign_small(sign_small), .mag(mag), .sign_out(sign_r), .is_zero(zero_c)
  );

  nnfp_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .HB(HB), .NORM_MODE(NORM_MODE)) u_norm (
    .mag(mag), .exp_in(exp_big), .sign_in(sign_r), .is_zero(zero_c),
    .bypass(bypass_c), .pass_word(pass_c), .result(result_c)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= result_c;
  end

  // R9: a far-apart operand pair forwards the larger word unchanged
  p_bypass_pass_r9: assert property (@(posedge clk) disable iff (rst)
    bypass_c |=> (sum_q == $past(pass_c)));

  // R8: exact cancellation yields the all-zero word
  p_zero_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (zero_c && !bypass_c) |=> (sum_q == '0));
endmodule

// File: tb/tb_nnfp_adder.sv
module tb_nnfp_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] sum_h, sum_t;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  nnfp_adder dut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum_q(sum_h));
  nnfp_adder #(.NORM_MODE(0), .ROUND_MODE(0)) dut_trunc (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum_q(sum_t));

  function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] m);
    return {s, 8'(e), m};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    chk("R2 reset hub", sum_h, 32'h0);
    chk("R2 reset trunc", sum_t, 32'h0);
    rst = 1'b0;
    drive(mk(0, 10, 23'h200000), mk(0, 10, 23'h100000));
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 mid reset", sum_t, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_same_sign;
    drive(mk(0, 10, 23'h200000), mk(0, 10, 23'h100000));
    chk("R3 add trunc", sum_t, mk(0, 10, 23'h300000));
    chk("R10 R12 add hub norm", sum_h, mk(0, 9, 23'h600002));
  endtask

  task automatic t_overflow;
    drive(mk(0, 10, 23'h400000), mk(0, 10, 23'h400000));
    chk("R6 carry trunc", sum_t, mk(0, 11, 23'h400000));
    chk("R6 carry hub", sum_h, mk(0, 11, 23'h400000));
  endtask

  task automatic t_sub_sign;
    drive(mk(0, 10, 23'h300000), mk(1, 10, 23'h100000));
    chk("R4 R10 sub no norm", sum_t, mk(0, 10, 23'h200000));
    chk("R10 sub hub norm", sum_h, mk(0, 9, 23'h400000));
    drive(mk(0, 10, 23'h100000), mk(1, 10, 23'h300000));
    chk("R4 sign of larger", sum_t, mk(1, 10, 23'h200000));
  endtask

  task automatic t_align;
    drive(mk(0, 12, 23'h000010), mk(0, 10, 23'h00000F));
    chk("R5 align truncate", sum_t, mk(0, 12, 23'h000013));
    drive(mk(0, 12, 23'h400000), mk(0, 11, 23'h400000));
    chk("R5 R12 align hub", sum_h, mk(0, 12, 23'h600000));
  endtask

  task automatic t_unnorm_swap;
    drive(mk(0, 11, 23'h000001), mk(1, 10, 23'h400000));
    chk("R4 unnormalized minuend", sum_t, mk(1, 11, 23'h1FFFFF));
  endtask

  task automatic t_bypass;
    drive(mk(0, 40, 23'h123456), mk(1, 10, 23'h7FFFFF));
    chk("R9 bypass trunc", sum_t, mk(0, 40, 23'h123456));
    drive(mk(0, 50, 23'h7FFFFF), mk(1, 100, 23'h0ABCDE));
    chk("R9 bypass hub", sum_h, mk(1, 100, 23'h0ABCDE));
  endtask

  task automatic t_boundary;
    drive(mk(0, 30, 23'h000000), mk(0, 7, 23'h7FFFFF));
    chk("R9 R8 diff 23 trunc", sum_t, 32'h0);
    chk("R9 diff 23 hub", sum_h, mk(0, 28, 23'h000004));
    drive(mk(0, 31, 23'h000000), mk(0, 7, 23'h7FFFFF));
    chk("R9 diff 24 trunc", sum_t, mk(0, 31, 23'h000000));
    chk("R9 diff 24 hub", sum_h, mk(0, 31, 23'h000000));
  endtask

  task automatic t_cancel;
    drive(mk(0, 20, 23'h2AAAAA), mk(1, 20, 23'h2AAAAA));
    chk("R8 cancel trunc", sum_t, 32'h0);
    drive(mk(1, 5, 23'h123456), mk(0, 5, 23'h123456));
    chk("R8 cancel hub", sum_h, 32'h0);
  endtask

  task automatic t_saturate;
    drive(mk(0, 255, 23'h600000), mk(0, 255, 23'h600000));
    chk("R7 saturate trunc", sum_t, 32'h7FFFFFFF);
    chk("R7 saturate hub", sum_h, 32'h7FFFFFFF);
  endtask

  task automatic t_limited;
    drive(mk(0, 10, 23'h000100), mk(0, 10, 23'h000100));
    chk("R10 shift capped at two", sum_h, mk(0, 8, 23'h000804));
    drive(mk(0, 1, 23'h000100), mk(0, 1, 23'h000100));
    chk("R11 exponent clamp", sum_h, mk(0, 0, 23'h000402));
  endtask

  task automatic t_commute;
    drive(mk(1, 10, 23'h300000), mk(0, 10, 23'h400000));
    chk("R13 swapped operands", sum_h, mk(0, 8, 23'h400000));
    drive(mk(1, 10, 23'h400000), mk(0, 11, 23'h000001));
    chk("R13 swapped unnormalized", sum_t, mk(1, 11, 23'h1FFFFF));
    chk("R1 sign field", {31'h0, sum_t[31]}, 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_same_sign();
    t_overflow();
    t_sub_sign();
    t_align();
    t_unnorm_swap();
    t_bypass();
    t_boundary();
    t_cancel();
    t_saturate();
    t_limited();
    t_commute();
    summary();
  end
endmodule